// File: doc/BRIEF.md
# Blink and Reverse Pixel Attribute Overlay

This block sits in the pixel path of a dot-matrix display controller, between the frame memory readout and the segment drivers. For each pixel it receives the line number, the segment column and a 2-bit gray level. One clock later it returns a level that may have been changed by two independent attributes, reverse and blink. Reverse complements the level. Blink blanks the pixel to level 0 during the off half of a slow phase.

Each attribute has its own area. The vertical extent of an area is an inclusive range of lines. The horizontal extent is a mask of 128 bits, one per segment column, held as 16 bytes. A CPU-side write port loads the mask one byte at a time through a column pointer that steps forward by itself. After the areas are set up, enable bits in the control register switch each attribute on. The blink phase is a divider of an external frame tick. With the default divider and a frame tick near 120 Hz, the phase toggles about every half second.

Top module: `disp_attr_overlay`

## Requirements
- R1: After reset, out_valid, out_level and blink_phase are 0. The control register clears to 0, which selects black/white mode with both attributes disabled.
- R2: The design registers each pixel once. out_valid equals px_valid one cycle later, and out_level then holds the result for that pixel.
- R3: In four-level mode (control bit 2 set), a pixel hit by reverse with reverse enabled leaves as the bitwise complement of its level: 00 becomes 11, 01 becomes 10, 10 becomes 01 and 11 becomes 00.
- R4: In black/white mode (control bit 2 clear), only bit 0 of px_level is used and out_level bit 1 is 0. Reverse complements bit 0.
- R5: Mask byte n covers segments 8n to 8n+7, and bit b of that byte covers segment 8n+b. A pixel whose mask bit is 0 is not affected.
- R6: A write to a channel's data register stores the byte at the channel's column pointer, then adds 1 to the pointer. The pointer wraps from 15 to 0. A write to the channel's column register loads the pointer.
- R7: A line is inside an area when start <= line <= end, including both limits. When start > end, no line is inside.
- R8: An attribute acts only while its enable bit is set: bit 0 for blink, bit 1 for reverse. With both bits clear in four-level mode, the level passes through unchanged.
- R9: blink_phase toggles on every HALF_PERIOD-th tick pulse. While it is 1, a blink-hit pixel with blink enabled leaves as level 0. While it is 0, blink has no effect.
- R10: When blink and reverse both hit a pixel, the block applies the inversion first. During the blink off phase, blanking then forces level 0.
- R11: Writes to register addresses 9 to 15 change nothing. Register addresses are: 0 control, 1/2/3/4 blink start/end/column/data, 5/6/7/8 reverse start/end/column/data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Frame tick that advances the blink divider |
| px_valid | input | 1 | Pixel present |
| px_line | input | LINE_W | Line number of the pixel |
| px_seg | input | SEG_W | Segment column of the pixel |
| px_level | input | 2 | Gray level in |
| out_valid | output | 1 | Modified pixel present |
| out_level | output | 2 | Modified gray level |
| blink_phase | output | 1 | 1 during the blink off phase |

## Verification
The hardest case to reach is a pixel where both areas overlap while the blink off phase is active. Reaching it needs the divider to advance through a whole half-period, and the two masks and both line ranges must be set up so that they coincide. The bench builds the design with a half-period of three ticks and drives tick pulses directly. It places both masks on the same byte through their column pointers, so the overlap can be checked in both phases, and again after blink is disabled.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic [3:0] {
    A_CTRL      = 4'd0,
    A_BLK_START = 4'd1,
    A_BLK_END   = 4'd2,
    A_BLK_X     = 4'd3,
    A_BLK_DATA  = 4'd4,
    A_REV_START = 4'd5,
    A_REV_END   = 4'd6,
    A_REV_X     = 4'd7,
    A_REV_DATA  = 4'd8
  } reg_addr_e;

  localparam int CTRL_BLINK_BIT = 0;
  localparam int CTRL_REV_BIT   = 1;
  localparam int CTRL_GRAY4_BIT = 2;
  localparam int CTRL_W         = 3;

  localparam int CH_BLINK = 0;
  localparam int CH_REV   = 1;
  localparam int NUM_CH   = 2;
endpackage

// File: rtl/attr_channel.sv
// One attribute area: inclusive line range plus a per-column mask.
module attr_channel #(
  parameter int LINE_W = 7,
  parameter int BYTES  = 16,
  localparam int XW    = $clog2(BYTES),
  localparam int SEG_W = XW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              wr_x,
  input  logic              wr_mask,
  input  logic [7:0]        wdata,
  input  logic [LINE_W-1:0] line,
  input  logic [SEG_W-1:0]  seg,
  output logic              hit
);
  logic [LINE_W-1:0] start_q, start_d;
  logic [LINE_W-1:0] end_q, end_d;
  logic [XW-1:0]     x_q, x_d;
  logic [7:0]        mask_q [BYTES];
  logic [7:0]        mask_d [BYTES];

  always_comb begin
    start_d = wr_start ? wdata[LINE_W-1:0] : start_q;
    end_d   = wr_end   ? wdata[LINE_W-1:0] : end_q;
    mask_d  = mask_q;
    x_d     = x_q;
    if (wr_x) begin
      x_d = wdata[XW-1:0];
    end else if (wr_mask) begin
      mask_d[x_q] = wdata;
      x_d = (x_q == XW'(BYTES - 1)) ? '0 : x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      x_q     <= '0;
      for (int i = 0; i < BYTES; i++) mask_q[i] <= '0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      x_q     <= x_d;
      mask_q  <= mask_d;
    end
  end

  logic in_range;
  assign in_range = (line >= start_q) && (line <= end_q);
  assign hit      = in_range && mask_q[seg[SEG_W-1:3]][seg[2:0]];
endmodule

// File: rtl/blink_timer.sv
// Divides the frame tick into a slow on/off phase.
module blink_timer #(
  parameter int HALF_PERIOD = 60,
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_PERIOD - 1));

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (tick) begin
      cnt_d   = wrap ? '0 : cnt_q + 1'b1;
      phase_d = wrap ? ~phase_q : phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/level_mod.sv
// Applies reverse first, then blink blanking, to one pixel level.
module level_mod (
  input  logic       gray4,
  input  logic       rev_on,
  input  logic       blank_on,
  input  logic [1:0] lvl_in,
  output logic [1:0] lvl_out
);
  logic [1:0] base, inv, rv;
  always_comb begin
    base    = gray4 ? lvl_in : {1'b0, lvl_in[0]};
    inv     = gray4 ? ~base  : {1'b0, ~base[0]};
    rv      = rev_on ? inv : base;
    lvl_out = blank_on ? 2'b00 : rv;
  end
endmodule

// File: rtl/disp_attr_overlay.sv
module disp_attr_overlay #(
  parameter int LINE_W      = 7,
  parameter int MASK_BYTES  = 16,
  parameter int HALF_PERIOD = 60,
  localparam int SEG_W      = $clog2(MASK_BYTES) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tick,
  input  logic              px_valid,
  input  logic [LINE_W-1:0] px_line,
  input  logic [SEG_W-1:0]  px_seg,
  input  logic [1:0]        px_level,
  output logic              out_valid,
  output logic [1:0]        out_level,
  output logic              blink_phase
);
  import attr_pkg::*;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] sel_start, sel_end, sel_x, sel_mask, ch_hit;

  always_comb begin
    ctrl_d    = ctrl_q;
    sel_start = '0;
    sel_end   = '0;
    sel_x     = '0;
    sel_mask  = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:      ctrl_d = wr_data[CTRL_W-1:0];
        A_BLK_START: sel_start[CH_BLINK] = 1'b1;
        A_BLK_END:   sel_end[CH_BLINK]   = 1'b1;
        A_BLK_X:     sel_x[CH_BLINK]     = 1'b1;
        A_BLK_DATA:  sel_mask[CH_BLINK]  = 1'b1;
        A_REV_START: sel_start[CH_REV]   = 1'b1;
        A_REV_END:   sel_end[CH_REV]     = 1'b1;
        A_REV_X:     sel_x[CH_REV]       = 1'b1;
        A_REV_DATA:  sel_mask[CH_REV]    = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    attr_channel #(.LINE_W(LINE_W), .BYTES(MASK_BYTES)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_start(sel_start[c]), .wr_end(sel_end[c]),
      .wr_x(sel_x[c]), .wr_mask(sel_mask[c]),
      .wdata(wr_data), .line(px_line), .seg(px_seg),
      .hit(ch_hit[c])
    );
  end

  blink_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(blink_phase)
  );

  logic       rev_on, blank_on;
  logic [1:0] lvl_mod;
  assign rev_on   = ctrl_q[CTRL_REV_BIT] & ch_hit[CH_REV];
  assign blank_on = ctrl_q[CTRL_BLINK_BIT] & ch_hit[CH_BLINK] & blink_phase;

  level_mod u_mod (
    .gray4(ctrl_q[CTRL_GRAY4_BIT]), .rev_on(rev_on), .blank_on(blank_on),
    .lvl_in(px_level), .lvl_out(lvl_mod)
  );

  logic [1:0] lvl_q, lvl_d;
  logic       vld_q;
  assign lvl_d = px_valid ? lvl_mod : lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      vld_q <= px_valid;
      lvl_q <= lvl_d;
    end
  end

  assign out_valid = vld_q;
  assign out_level = lvl_q;
endmodule

// File: rtl/attr_overlay_checker.sv
module attr_overlay_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       px_valid,
  input logic [1:0] px_level,
  input logic       tick,
  input logic       blink_phase,
  input logic       out_valid,
  input logic [1:0] out_level,
  input logic       blink_en,
  input logic       rev_en,
  input logic       gray4,
  input logic       blink_hit
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> !out_valid);
  assert_bw_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !gray4) |=> (out_level[1] == 1'b0));
  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && gray4 && !rev_en && !blink_en) |=> (out_level == $past(px_level)));
  assert_phase_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(blink_phase));
  assert_blank_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && blink_en && blink_hit && blink_phase) |=> (out_level == 2'b00));
endmodule

bind disp_attr_overlay attr_overlay_checker u_chk (
  .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_level(px_level),
  .tick(tick), .blink_phase(blink_phase), .out_valid(out_valid),
  .out_level(out_level), .blink_en(ctrl_q[0]), .rev_en(ctrl_q[1]),
  .gray4(ctrl_q[2]), .blink_hit(ch_hit[0])
);

// File: tb/sim_disp_attr_overlay.sv
`timescale 1ns/1ps
module sim_disp_attr_overlay;
  localparam int LW = 7;
  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          tick = 1'b0;
  logic          px_valid = 1'b0;
  logic [LW-1:0] px_line = '0;
  logic [SW-1:0] px_seg = '0;
  logic [1:0]    px_level = '0;
  logic          out_valid;
  logic [1:0]    out_level;
  logic          blink_phase;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_attr_overlay #(.LINE_W(LW), .MASK_BYTES(16), .HALF_PERIOD(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .px_valid(px_valid), .px_line(px_line),
    .px_seg(px_seg), .px_level(px_level), .out_valid(out_valid),
    .out_level(out_level), .blink_phase(blink_phase)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pix(input int line, input int seg, input logic [1:0] lvl,
                     input logic [1:0] exp, input string req);
    @(negedge clk);
    px_valid = 1'b1; px_line = LW'(line); px_seg = SW'(seg); px_level = lvl;
    @(negedge clk);
    px_valid = 1'b0;
    chk(req, int'(out_level), int'(exp));
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_level", int'(out_level), 0);
    chk("R1 blink_phase", int'(blink_phase), 0);
    pix(10, 0, 2'b11, 2'b01, "R1 default black/white passthrough");
  endtask

  task automatic test_valid;
    @(negedge clk);
    px_valid = 1'b1; px_level = 2'b01;
    @(negedge clk);
    px_valid = 1'b0;
    chk("R2 valid after one cycle", int'(out_valid), 1);
    @(negedge clk);
    chk("R2 valid drops", int'(out_valid), 0);
  endtask

  task automatic test_enable_gate;
    wr(4'd5, 8'd10); wr(4'd6, 8'd20); wr(4'd7, 8'd0); wr(4'd8, 8'h01);
    wr(4'd0, 8'b100);
    pix(12, 0, 2'b01, 2'b01, "R8 reverse disabled");
  endtask

  task automatic test_reverse4;
    wr(4'd0, 8'b110);
    pix(12, 0, 2'b00, 2'b11, "R3 00->11");
    pix(12, 0, 2'b01, 2'b10, "R3 01->10");
    pix(12, 0, 2'b10, 2'b01, "R3 10->01");
    pix(12, 0, 2'b11, 2'b00, "R3 11->00");
    pix(12, 1, 2'b01, 2'b01, "R5 clear bit unaffected");
    wr(4'd8, 8'h80);
    pix(12, 15, 2'b10, 2'b01, "R5 byte1 bit7 = seg15");
    pix(12, 14, 2'b10, 2'b10, "R5 seg14 clear");
    pix(12, 8, 2'b10, 2'b10, "R5 seg8 clear");
  endtask

  task automatic test_range;
    pix(9, 0, 2'b01, 2'b01, "R7 below start");
    pix(10, 0, 2'b01, 2'b10, "R7 start inclusive");
    pix(20, 0, 2'b01, 2'b10, "R7 end inclusive");
    pix(21, 0, 2'b01, 2'b01, "R7 above end");
  endtask

  task automatic test_xaddr;
    wr(4'd7, 8'd14);
    wr(4'd8, 8'h01); wr(4'd8, 8'h01); wr(4'd8, 8'h02);
    pix(12, 112, 2'b00, 2'b11, "R6 byte14");
    pix(12, 120, 2'b00, 2'b11, "R6 byte15");
    pix(12, 0, 2'b00, 2'b00, "R6 wrap overwrote byte0 bit0");
    pix(12, 1, 2'b00, 2'b11, "R6 wrap wrote byte0 bit1");
    wr(4'd7, 8'd5); wr(4'd8, 8'h10);
    pix(12, 44, 2'b00, 2'b11, "R6 pointer reload byte5");
    pix(12, 48, 2'b00, 2'b00, "R6 byte6 untouched");
  endtask

  task automatic test_bw;
    wr(4'd0, 8'b010);
    pix(12, 1, 2'b00, 2'b01, "R4 0->1");
    pix(12, 1, 2'b01, 2'b00, "R4 1->0");
    pix(12, 1, 2'b10, 2'b01, "R4 bit1 ignored");
    pix(12, 2, 2'b11, 2'b01, "R4 miss keeps bit0 only");
  endtask

  task automatic test_empty_range;
    wr(4'd0, 8'b110);
    wr(4'd5, 8'd30); wr(4'd6, 8'd25);
    pix(25, 1, 2'b00, 2'b00, "R7 start>end line 25");
    pix(27, 1, 2'b00, 2'b00, "R7 start>end line 27");
    pix(30, 1, 2'b00, 2'b00, "R7 start>end line 30");
  endtask

  task automatic test_blink;
    wr(4'd0, 8'b101);
    wr(4'd1, 8'd40); wr(4'd2, 8'd40); wr(4'd3, 8'd2); wr(4'd4, 8'hFF);
    pix(40, 16, 2'b10, 2'b10, "R9 on phase passes");
    pulse_tick(2);
    chk("R9 phase holds before period", int'(blink_phase), 0);
    pulse_tick(1);
    chk("R9 phase toggles", int'(blink_phase), 1);
    pix(40, 16, 2'b10, 2'b00, "R9 off phase blanks seg16");
    pix(40, 23, 2'b11, 2'b00, "R9 off phase blanks seg23");
    pix(41, 16, 2'b11, 2'b11, "R9 outside line");
    pix(40, 24, 2'b11, 2'b11, "R9 outside mask");
    pulse_tick(3);
    chk("R9 phase back on", int'(blink_phase), 0);
    pix(40, 16, 2'b11, 2'b11, "R9 on again passes");
  endtask

  task automatic test_overlap;
    wr(4'd5, 8'd35); wr(4'd6, 8'd45); wr(4'd7, 8'd2); wr(4'd8, 8'h01);
    wr(4'd0, 8'b111);
    pix(40, 16, 2'b01, 2'b10, "R10 on phase inverts");
    pulse_tick(3);
    pix(40, 16, 2'b01, 2'b00, "R10 off phase blank wins");
    pix(40, 17, 2'b01, 2'b00, "R10 blink only");
    wr(4'd0, 8'b110);
    pix(40, 16, 2'b01, 2'b10, "R8 blink disabled in off phase");
  endtask

  task automatic test_unused;
    for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
    pix(40, 16, 2'b01, 2'b10, "R11 control kept");
    pix(40, 17, 2'b01, 2'b01, "R11 mask kept");
    pix(12, 0, 2'b00, 2'b00, "R11 range kept");
    wr(4'd8, 8'h02);
    pix(40, 25, 2'b00, 2'b11, "R11 pointer kept");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_valid();
    test_enable_gate();
    test_reverse4();
    test_range();
    test_xaddr();
    test_bw();
    test_empty_range();
    test_blink();
    test_overlap();
    test_unused();
    done = 1'b1;
    finish_run();
  end
endmodule